// File: doc/BRIEF.md
# Descriptor Cache Flush Controller

This block executes flush commands against a small direct-mapped descriptor cache. The cache keeps a tag, a valid bit and a dirty bit for each line, and the block models that array internally. Software-side logic sends a command as nine 32-bit beats on a valid/ready input. The controller decodes the command and then runs a fixed sequence. It can free a blocking slot, check whether a slot can be claimed, ask an external queue engine to drain the entries tied to the address, write the line out, and lock the address into one of four blocking slots. When the command asks for it, a one-cycle status record carries the command number and a result code.

Cache clients reach the array through a lookup port. A lookup misses and allocates the line, or it hits and may mark the line dirty. A lookup to an address held by any blocking slot is stalled by `lk_ready` low. While the whole cache is locked, every lookup is stalled. A separate unblock input frees one slot or lifts the whole-cache lock.

The controller is a single state machine. `S_COLLECT` accepts beats. `S_RELEASE` frees the chosen slot or fails with code 1. `S_CHECK` fails with code 2 on a busy slot, otherwise it routes to `S_FORWARD` or `S_FLUSH`. `S_FORWARD` holds the drain request until it is acknowledged. `S_FLUSH` writes back a dirty hit and updates the line. `S_CLAIM` loads the slot. `S_FLUSH_ALL` walks every line. `S_REPORT` emits the status and returns to `S_COLLECT`.

The transitions out of `S_COLLECT` on the last beat are as follows:
- A whole-cache command goes to `S_FLUSH_ALL`.
- A command with release set goes to `S_RELEASE`.
- Any other command goes to `S_CHECK`.

The remaining transitions are:
- `S_RELEASE` goes to `S_CHECK`, or to `S_REPORT` on error.
- `S_CHECK` goes to `S_REPORT` on error, else to `S_FORWARD` or `S_FLUSH`.
- `S_FORWARD` goes to `S_FLUSH` on `fwd_done`.
- `S_FLUSH` goes to `S_CLAIM` or `S_REPORT` once the writeback is taken or none is needed.
- `S_CLAIM` goes to `S_REPORT`.
- `S_FLUSH_ALL` goes to `S_REPORT` after the last line.
- `S_REPORT` goes to `S_COLLECT`.

Top module: `desc_flush_ctrl`

## Requirements
- R1: A command is nine beats, each transferred when `cmd_valid` and `cmd_ready` are both high. In beat 0, bits [15:0] are the command number and bit 16 requests a status record. Beat 1 carries address bits [31:0]. Beat 2 bits [7:0] carry address bits [39:32].
- R2: Beat 2 control bits are as follows: bit 8 forward first, bit 9 release slot, bits [11:10] slot index, bit 12 keep line valid, bit 13 block after flush, bit 14 whole-cache flush. Nonzero values in beat 2 bits [31:15], beat 0 bits [31:17] and beats 3 to 8 have no effect.
- R3: `cmd_ready` is low from the cycle after the last beat is taken until the cycle after the report step. It is never high while `wb_valid` or `fwd_req` is high, and it is high again in the cycle after a status pulse.
- R4: With release set and the selected slot free, the command does nothing else. It reports code 1 with no writeback and no forward request.
- R5: With release set and the slot busy, the slot is freed first. A block request in the same command then claims that slot and reports code 0.
- R6: With block set and the slot still busy after any release, the command reports code 2 and performs no flush. The line keeps its dirty state.
- R7: A successful block loads the slot with the flushed address. Lookups to that address see `lk_ready` low, while lookups to other addresses proceed. A single-slot unblock (`ub_whole`=0) frees it.
- R8: A flush of a dirty hit raises `wb_valid` with the line address and holds it until `wb_ready`. Unless bit 12 is set, the line is then invalid, so a later lookup misses.
- R9: With bit 12 set, the dirty line is written back and stays valid but clean, so a later lookup hits and a second such flush writes nothing.
- R10: With bit 8 set, `fwd_req` is raised with the command address and held until `fwd_done`. No writeback for the command starts before `fwd_done`.
- R11: A flush of an address that is absent, or present but clean, reports code 0 with no writeback.
- R12: A whole-cache flush ignores every other control field. It writes back all dirty lines in ascending index order and invalidates every line. All lookups are stalled from then until an unblock with `ub_whole`=1. The four slots are left as they were.
- R13: A status pulse (`st_valid` for one cycle) is produced only when beat 0 bit 16 is set. It echoes the command number on `st_num`, and `st_code` is 0 for success, 1 for releasing a free slot, or 2 for a busy slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Controller accepts a beat |
| cmd_data | input | 32 | Command beat |
| lk_valid | input | 1 | Client lookup request |
| lk_addr | input | 40 | Lookup address |
| lk_write | input | 1 | Lookup modifies the line (sets dirty) |
| lk_ready | output | 1 | Lookup accepted (low while address or cache is blocked) |
| lk_hit | output | 1 | Lookup address present in the cache |
| ub_valid | input | 1 | Unblock command |
| ub_whole | input | 1 | 1: lift whole-cache lock, 0: free one slot |
| ub_slot | input | 2 | Slot to free |
| wb_valid | output | 1 | Line writeback request |
| wb_ready | input | 1 | Writeback taken |
| wb_addr | output | 40 | Address of the written line |
| fwd_req | output | 1 | Request to drain queued entries |
| fwd_addr | output | 40 | Address whose queue is drained |
| fwd_done | input | 1 | Drain finished |
| st_valid | output | 1 | Status record pulse |
| st_num | output | 16 | Echoed command number |
| st_code | output | 2 | Result code |

## Verification
A wrong slot bit shows up in two places. If a slot is left busy, the next block request on that slot reports code 2 in the report cycle. If a slot is lost, a lookup to the locked address sees `lk_ready` high in the same cycle it is presented. A dirty or valid bit that is not updated appears on the next flush as a writeback that should not happen, or a missing one, within a few cycles of the last beat. It also appears as a wrong `lk_hit` on the next lookup. A whole-cache lock that is not set, or that clears too early, is visible on the first lookup after the command.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
    localparam int ADDR_W = 40;
    localparam int WORD_W = 32;
    localparam int NUM_W  = 16;
    localparam int SLOTS  = 4;
    localparam int SLOT_W = 2;

    typedef enum logic [1:0] {
        CODE_OK        = 2'd0,
        CODE_REL_FREE  = 2'd1,
        CODE_SLOT_BUSY = 2'd2
    } code_e;

    typedef enum logic [2:0] {
        S_COLLECT,
        S_RELEASE,
        S_CHECK,
        S_FORWARD,
        S_FLUSH,
        S_CLAIM,
        S_FLUSH_ALL,
        S_REPORT
    } state_e;

    typedef struct packed {
        logic [NUM_W-1:0]  num;
        logic              want_status;
        logic [ADDR_W-1:0] addr;
        logic              fwd;
        logic              rel;
        logic [SLOT_W-1:0] slot;
        logic              keep;
        logic              blk;
        logic              whole;
    } cmd_t;
endpackage

// File: rtl/dfc_cmd_collect.sv
module dfc_cmd_collect
    import dfc_pkg::*;
#(
    parameter int CMD_WORDS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [WORD_W-1:0] data,
    output logic              last,
    output cmd_t              cmd
);
    localparam int CNT_W = $clog2(CMD_WORDS);

    logic [CNT_W-1:0] cnt_q;

    assign last = fire && (cnt_q == CNT_W'(CMD_WORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmd   <= '0;
        end else if (fire) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(0)) begin
                cmd.num         <= data[15:0];
                cmd.want_status <= data[16];
            end else if (cnt_q == CNT_W'(1)) begin
                cmd.addr[31:0] <= data;
            end else if (cnt_q == CNT_W'(2)) begin
                cmd.addr[39:32] <= data[7:0];
                cmd.fwd         <= data[8];
                cmd.rel         <= data[9];
                cmd.slot        <= data[11:10];
                cmd.keep        <= data[12];
                cmd.blk         <= data[13];
                cmd.whole       <= data[14];
            end
        end
    end
endmodule

// File: rtl/dfc_line_array.sv
module dfc_line_array
    import dfc_pkg::*;
#(
    parameter int LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_fire,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_write,
    output logic              lk_hit,
    input  logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [ADDR_W-1:0] rd_tag,
    input  logic              upd_en,
    input  logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] upd_idx,
    input  logic              upd_inval
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [ADDR_W-1:0] tag_q [LINES];
    logic [LINES-1:0]  match;
    logic [IDX_W-1:0]  lk_idx;

    assign lk_idx = lk_addr[IDX_W-1:0];

    for (genvar g = 0; g < LINES; g++) begin : g_match
        assign match[g] = valid_q[g] && (tag_q[g] == lk_addr);
    end

    assign lk_hit   = match[lk_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (upd_en && (upd_idx == IDX_W'(i))) begin
                    if (upd_inval) valid_q[i] <= 1'b0;
                    dirty_q[i] <= 1'b0;
                end else if (lk_fire && (lk_idx == IDX_W'(i))) begin
                    if (match[i]) begin
                        dirty_q[i] <= dirty_q[i] | lk_write;
                    end else begin
                        tag_q[i]   <= lk_addr;
                        valid_q[i] <= 1'b1;
                        dirty_q[i] <= lk_write;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dfc_block_slots.sv
module dfc_block_slots
    import dfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [SLOT_W-1:0] set_idx,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [SLOT_W-1:0] clr_idx,
    input  logic              ub_valid,
    input  logic              ub_whole,
    input  logic [SLOT_W-1:0] ub_idx,
    input  logic              glob_set,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [SLOTS-1:0]  busy,
    output logic              addr_blocked,
    output logic              glob_blk
);
    logic [ADDR_W-1:0] addr_q [SLOTS];
    logic [SLOTS-1:0]  hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit[g] = busy[g] && (addr_q[g] == chk_addr);
    end

    assign addr_blocked = |hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= '0;
            glob_blk <= 1'b0;
            for (int i = 0; i < SLOTS; i++) addr_q[i] <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (ub_valid && !ub_whole && (ub_idx == SLOT_W'(i))) busy[i] <= 1'b0;
                if (clr_en && (clr_idx == SLOT_W'(i))) busy[i] <= 1'b0;
                if (set_en && (set_idx == SLOT_W'(i))) begin
                    busy[i]   <= 1'b1;
                    addr_q[i] <= set_addr;
                end
            end
            if (glob_set) glob_blk <= 1'b1;
            else if (ub_valid && ub_whole) glob_blk <= 1'b0;
        end
    end
endmodule

// File: rtl/desc_flush_ctrl.sv
module desc_flush_ctrl
    import dfc_pkg::*;
#(
    parameter int LINES     = 4,
    parameter int CMD_WORDS = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    output logic         cmd_ready,
    input  logic [31:0]  cmd_data,
    input  logic         lk_valid,
    input  logic [39:0]  lk_addr,
    input  logic         lk_write,
    output logic         lk_ready,
    output logic         lk_hit,
    input  logic         ub_valid,
    input  logic         ub_whole,
    input  logic [1:0]   ub_slot,
    output logic         wb_valid,
    input  logic         wb_ready,
    output logic [39:0]  wb_addr,
    output logic         fwd_req,
    output logic [39:0]  fwd_addr,
    input  logic         fwd_done,
    output logic         st_valid,
    output logic [15:0]  st_num,
    output logic [1:0]   st_code
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    state_e            state_q, state_d;
    code_e             code_q, code_d;
    logic [IDX_W-1:0]  idx_q, idx_d;

    cmd_t              cmd;
    logic              cmd_fire, cmd_last;
    logic              lk_fire;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_valid, rd_dirty;
    logic [ADDR_W-1:0] rd_tag;
    logic              tag_ok, line_hit, line_wb, step_done;
    logic              upd_en, upd_inval;
    logic [SLOTS-1:0]  slot_busy;
    logic              addr_blocked, glob_blk;
    logic              set_en, clr_en, glob_set;

    assign cmd_fire = cmd_valid && cmd_ready;
    assign lk_fire  = lk_valid && lk_ready;

    dfc_cmd_collect #(.CMD_WORDS(CMD_WORDS)) u_collect (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (cmd_fire),
        .data (cmd_data),
        .last (cmd_last),
        .cmd  (cmd)
    );

    dfc_line_array #(.LINES(LINES)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_fire  (lk_fire),
        .lk_addr  (lk_addr),
        .lk_write (lk_write),
        .lk_hit   (lk_hit),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .upd_en   (upd_en),
        .upd_idx  (rd_idx),
        .upd_inval(upd_inval)
    );

    dfc_block_slots u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (set_en),
        .set_idx     (cmd.slot),
        .set_addr    (cmd.addr),
        .clr_en      (clr_en),
        .clr_idx     (cmd.slot),
        .ub_valid    (ub_valid),
        .ub_whole    (ub_whole),
        .ub_idx      (ub_slot),
        .glob_set    (glob_set),
        .chk_addr    (lk_addr),
        .busy        (slot_busy),
        .addr_blocked(addr_blocked),
        .glob_blk    (glob_blk)
    );

    // Line selection: counter during the whole-cache walk, address index otherwise
    assign rd_idx    = (state_q == S_FLUSH_ALL) ? idx_q : cmd.addr[IDX_W-1:0];
    assign tag_ok    = (state_q == S_FLUSH_ALL) || (rd_tag == cmd.addr);
    assign line_hit  = rd_valid && tag_ok;
    assign line_wb   = line_hit && rd_dirty;
    assign step_done = !line_wb || wb_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_COLLECT;
            code_q  <= CODE_OK;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_COLLECT: begin
                if (cmd_last) begin
                    code_d = CODE_OK;
                    idx_d  = '0;
                    if (cmd.whole)    state_d = S_FLUSH_ALL;
                    else if (cmd.rel) state_d = S_RELEASE;
                    else              state_d = S_CHECK;
                end
            end
            S_RELEASE: begin
                if (!slot_busy[cmd.slot]) begin
                    code_d  = CODE_REL_FREE;
                    state_d = S_REPORT;
                end else begin
                    state_d = S_CHECK;
                end
            end
            S_CHECK: begin
                if (cmd.blk && slot_busy[cmd.slot]) begin
                    code_d  = CODE_SLOT_BUSY;
                    state_d = S_REPORT;
                end else begin
                    state_d = cmd.fwd ? S_FORWARD : S_FLUSH;
                end
            end
            S_FORWARD: begin
                if (fwd_done) state_d = S_FLUSH;
            end
            S_FLUSH: begin
                if (step_done) state_d = cmd.blk ? S_CLAIM : S_REPORT;
            end
            S_CLAIM: state_d = S_REPORT;
            S_FLUSH_ALL: begin
                if (step_done) begin
                    if (idx_q == IDX_W'(LINES - 1)) state_d = S_REPORT;
                    else idx_d = idx_q + IDX_W'(1);
                end
            end
            S_REPORT: state_d = S_COLLECT;
            default:  state_d = S_COLLECT;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        wb_valid  = 1'b0;
        fwd_req   = 1'b0;
        st_valid  = 1'b0;
        upd_en    = 1'b0;
        upd_inval = 1'b1;
        set_en    = 1'b0;
        clr_en    = 1'b0;
        glob_set  = 1'b0;
        unique case (state_q)
            S_COLLECT: begin
                cmd_ready = 1'b1;
                glob_set  = cmd_last && cmd.whole;
            end
            S_RELEASE: clr_en = slot_busy[cmd.slot];
            S_CHECK:   ;
            S_FORWARD: fwd_req = 1'b1;
            S_FLUSH: begin
                wb_valid  = line_wb;
                upd_en    = line_hit && step_done;
                upd_inval = !cmd.keep;
            end
            S_CLAIM:   set_en = 1'b1;
            S_FLUSH_ALL: begin
                wb_valid = line_wb;
                upd_en   = step_done;
            end
            S_REPORT:  st_valid = cmd.want_status;
            default:   ;
        endcase
    end

    assign lk_ready = !(glob_blk || addr_blocked);
    assign wb_addr  = rd_tag;
    assign fwd_addr = cmd.addr;
    assign st_num   = cmd.num;
    assign st_code  = code_q;
endmodule

// File: rtl/desc_flush_ctrl_chk.sv
module desc_flush_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        lk_ready,
    input logic        wb_valid,
    input logic        wb_ready,
    input logic [39:0] wb_addr,
    input logic        fwd_req,
    input logic        fwd_done,
    input logic [39:0] fwd_addr,
    input logic        st_valid,
    input logic        glob_blk
);
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr))); // R8

    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && !fwd_done) |=> (fwd_req && $stable(fwd_addr))); // R10

    AST_NO_WB_IN_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |-> !wb_valid); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid || fwd_req) |-> !cmd_ready); // R3

    AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> (!st_valid && cmd_ready)); // R13

    AST_WHOLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        glob_blk |-> !lk_ready); // R12
endmodule

bind desc_flush_ctrl desc_flush_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ready(cmd_ready),
    .lk_ready (lk_ready),
    .wb_valid (wb_valid),
    .wb_ready (wb_ready),
    .wb_addr  (wb_addr),
    .fwd_req  (fwd_req),
    .fwd_done (fwd_done),
    .fwd_addr (fwd_addr),
    .st_valid (st_valid),
    .glob_blk (glob_blk)
);

// File: tb/desc_flush_ctrl_test.sv
module desc_flush_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_data = '0;
    logic        lk_valid = 1'b0;
    logic [39:0] lk_addr = '0;
    logic        lk_write = 1'b0;
    logic        lk_ready, lk_hit;
    logic        ub_valid = 1'b0;
    logic        ub_whole = 1'b0;
    logic [1:0]  ub_slot = '0;
    logic        wb_valid;
    logic        wb_ready = 1'b0;
    logic [39:0] wb_addr;
    logic        fwd_req;
    logic [39:0] fwd_addr;
    logic        fwd_done = 1'b0;
    logic        st_valid;
    logic [15:0] st_num;
    logic [1:0]  st_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    desc_flush_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write),
        .lk_ready(lk_ready), .lk_hit(lk_hit),
        .ub_valid(ub_valid), .ub_whole(ub_whole), .ub_slot(ub_slot),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .fwd_req(fwd_req), .fwd_addr(fwd_addr), .fwd_done(fwd_done),
        .st_valid(st_valid), .st_num(st_num), .st_code(st_code)
    );

    localparam logic [39:0] A0 = 40'h5A_1234_5600;
    localparam logic [39:0] A1 = 40'h5A_1234_5601;
    localparam logic [39:0] A2 = 40'h5A_1234_5602;
    localparam logic [39:0] A3 = 40'h5A_1234_5603;
    localparam logic [39:0] BX = 40'h33_0000_0003;

    // row: fill, addr, ctl{blk,keep,slot[1:0],rel,fwd}, code, writebacks, forwards, post-lookup hit (2 = none)
    typedef struct packed {
        logic        fill;
        logic [39:0] addr;
        logic [5:0]  ctl;
        logic [1:0]  code;
        logic [1:0]  wbs;
        logic        fwd;
        logic [1:0]  post;
    } vec_t;
    localparam int NV = 9;
    localparam logic [53:0] VEC [NV] = '{
        {1'b1, A0, 6'b000000, 2'd0, 2'd1, 1'b0, 2'd0},
        {1'b0, A0, 6'b000000, 2'd0, 2'd0, 1'b0, 2'd2},
        {1'b1, A1, 6'b000110, 2'd1, 2'd0, 1'b0, 2'd2},
        {1'b0, A1, 6'b100100, 2'd0, 2'd1, 1'b0, 2'd2},
        {1'b1, A0, 6'b100100, 2'd2, 2'd0, 1'b0, 2'd2},
        {1'b0, A0, 6'b100110, 2'd0, 2'd1, 1'b0, 2'd2},
        {1'b1, A1, 6'b010000, 2'd0, 2'd1, 1'b0, 2'd1},
        {1'b0, A1, 6'b010000, 2'd0, 2'd0, 1'b0, 2'd2},
        {1'b1, A1, 6'b000001, 2'd0, 2'd1, 1'b1, 2'd2}
    };

    function automatic string row_tag(input int i);
        case (i)
            0: return "R8";
            1: return "R11";
            2: return "R4";
            3: return "R7";
            4: return "R6";
            5: return "R5";
            6: return "R9";
            7: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Port monitor, sampled on the falling edge
    int          wb_cnt = 0, st_cnt = 0, fwd_cnt = 0, fwd_wait = 0, bad_ready = 0;
    int          wb_at_fwd = 0;
    logic [39:0] wb_log [16];
    logic [39:0] fwd_last = '0;
    logic [15:0] st_num_l = '0;
    logic [1:0]  st_code_l = '0;

    always @(negedge clk) begin
        wb_ready = ~wb_ready;
        if (wb_valid && wb_ready) begin
            wb_log[wb_cnt % 16] = wb_addr;
            wb_cnt++;
        end
        if (st_valid) begin
            st_cnt++;
            st_num_l  = st_num;
            st_code_l = st_code;
        end
        if (cmd_ready && (wb_valid || fwd_req)) bad_ready++;
        if (fwd_req) begin
            fwd_wait++;
            if (fwd_wait == 3) begin
                fwd_done  = 1'b1;
                fwd_cnt++;
                fwd_last  = fwd_addr;
                wb_at_fwd = wb_cnt;
                fwd_wait  = 0;
            end else begin
                fwd_done = 1'b0;
            end
        end else begin
            fwd_done = 1'b0;
            fwd_wait = 0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [15:0] num, input logic want, input logic [39:0] addr,
                            input logic [6:0] ctl, input logic junk);
        logic [31:0] w [9];
        w[0] = {junk ? 15'h7fff : 15'h0, want, num};
        w[1] = addr[31:0];
        w[2] = {junk ? 17'h1ffff : 17'h0, ctl, addr[39:32]};
        for (int k = 3; k < 9; k++) w[k] = junk ? 32'hffff_ffff : 32'h0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_data  = w[k];
            #1;
            while (!cmd_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data  = '0;
        for (int t = 0; t < 200; t++) begin
            #1;
            if (cmd_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic look(input logic [39:0] a, input logic wr, output logic rdy, output logic hit);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        lk_write = wr;
        #1;
        rdy = lk_ready;
        hit = lk_hit;
        @(negedge clk);
        lk_valid = 1'b0;
        lk_write = 1'b0;
    endtask

    task automatic unblock(input logic whole, input logic [1:0] s);
        @(negedge clk);
        ub_valid = 1'b1;
        ub_whole = whole;
        ub_slot  = s;
        @(negedge clk);
        ub_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic rdy, hit;
        int   wb0, st0, fw0;
        vec_t v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R3 reset cmd_ready", cmd_ready, 1);
        chk("R13 reset st_valid", st_valid, 0);
        chk("R8 reset wb_valid", wb_valid, 0);
        chk("R10 reset fwd_req", fwd_req, 0);
        chk("R7 reset lk_ready", lk_ready, 1);

        for (int i = 0; i < NV; i++) begin
            v = vec_t'(VEC[i]);
            if (v.fill) look(v.addr, 1'b1, rdy, hit);
            wb0 = wb_cnt;
            st0 = st_cnt;
            fw0 = fwd_cnt;
            // odd rows carry nonzero reserved fields (R2)
            send_cmd(16'h0100 + 16'(i), 1'b1, v.addr, {1'b0, v.ctl}, i[0]);
            chk({row_tag(i), " R1 R13 status count"}, st_cnt - st0, 1);
            chk({row_tag(i), " R13 status number"}, st_num_l, 16'h0100 + 16'(i));
            chk({row_tag(i), " R2 status code"}, st_code_l, v.code);
            chk({row_tag(i), " writeback count"}, wb_cnt - wb0, v.wbs);
            if (v.wbs == 2'd1) chk({row_tag(i), " writeback address"}, wb_log[wb0 % 16], v.addr);
            chk({row_tag(i), " forward count"}, fwd_cnt - fw0, v.fwd);
            if (v.fwd) begin
                chk("R10 forward address", fwd_last, v.addr);
                chk("R10 no writeback before forward done", wb_at_fwd, wb0);
            end
            if (v.post != 2'd2) begin
                look(v.addr, 1'b0, rdy, hit);
                chk({row_tag(i), " post lookup hit"}, hit, v.post[0]);
            end
        end

        // R7: slot 1 holds A0 after the table
        look(A0, 1'b0, rdy, hit);
        chk("R7 blocked address stalls", rdy, 0);
        look(A1, 1'b0, rdy, hit);
        chk("R7 other address proceeds", rdy, 1);
        unblock(1'b0, 2'd1);
        look(A0, 1'b0, rdy, hit);
        chk("R7 single unblock frees address", rdy, 1);

        // R12: lock BX in slot 2, then flush the whole cache
        send_cmd(16'h0200, 1'b1, BX, 7'b0101000, 1'b0);
        chk("R11 absent block code", st_code_l, 0);
        look(A0, 1'b1, rdy, hit);
        look(A1, 1'b1, rdy, hit);
        look(A2, 1'b1, rdy, hit);
        look(A3, 1'b0, rdy, hit);
        wb0 = wb_cnt;
        send_cmd(16'h0201, 1'b1, A3, 7'b1100111, 1'b1);
        chk("R12 whole flush code ignores release", st_code_l, 0);
        chk("R12 whole flush writeback count", wb_cnt - wb0, 3);
        chk("R12 writeback order line0", wb_log[wb0 % 16], A0);
        chk("R12 writeback order line1", wb_log[(wb0 + 1) % 16], A1);
        chk("R12 writeback order line2", wb_log[(wb0 + 2) % 16], A2);
        look(A3, 1'b0, rdy, hit);
        chk("R12 cache locked stalls lookup", rdy, 0);
        unblock(1'b1, 2'd0);
        look(A3, 1'b0, rdy, hit);
        chk("R12 lookup after whole unblock", rdy, 1);
        chk("R12 lines invalidated", hit, 0);
        look(BX, 1'b0, rdy, hit);
        chk("R12 slot kept through whole flush", rdy, 0);
        unblock(1'b0, 2'd2);
        look(BX, 1'b0, rdy, hit);
        chk("R7 slot 2 freed", rdy, 1);

        // R13: no status requested
        st0 = st_cnt;
        send_cmd(16'h0300, 1'b0, A2, 7'b0000000, 1'b0);
        chk("R13 no status pulse", st_cnt - st0, 0);
        chk("R3 ready after silent command", cmd_ready, 1);
        chk("R3 ready never high while busy", bad_ready, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule